// File: doc/BRIEF.md
# Endpoint Data Object Mailbox Controller

This block is the hardware half of a data object mailbox in a PCIe endpoint function. The host pushes request dwords into a write-data FIFO through a small register port and then sets a GO control bit. The block raises a request interrupt toward local firmware. Firmware pops the request from the write-data FIFO, and the block decodes the two leading header dwords as they pass by. Firmware then answers through the read-data FIFO, which the host drains one dword at a time.

The block holds the mailbox status (ready, busy, error, abort pending). It builds the two response header dwords itself from a vendor, type and payload count that firmware supplies. It also resolves a host abort against a request that is in flight: the queued request data is discarded, the status is cleared, and a late response is dropped. A separate abort interrupt tells firmware to stop.

Top module: `doe_mbx_ctrl`

## Requirements
- R1: When firmware pops the first dword of a request, its bits 15:0 appear on `req_vendor` and its bits 23:16 on `req_type` from the next cycle on.
- R2: When firmware pops the second dword, `req_len` shows its bits 17:0 from the next cycle on, and `req_hdr_valid` rises. A field value of zero shows as 262144 (2^18).
- R3: A host write to address 0 with bit 0 (GO) set makes `irq_go` high for exactly the following cycle.
- R4: A host write to address 0 with bit 1 (ABORT) set has these effects. `irq_abort` is high for the following cycle. Both FIFOs are emptied. READY and ERROR are cleared. Abort-pending is set and stays set until `loc_abort_ack`, and that acknowledge also clears BUSY.
- R5: `loc_accept` sets BUSY unless an abort is pending, in which case it is ignored. `loc_done` or `loc_fail` while BUSY clears BUSY.
- R6: A `resp_hdr_en` pulse pushes two dwords into the read-data FIFO. The first, in the same cycle, is {8'h00, type, vendor}. The second, in the next cycle, is the payload count plus 2, taken modulo 2^18.
- R7: `loc_done` while BUSY and with no abort pending sets READY. READY clears in the cycle after the host pops the last dword of the read-data FIFO.
- R8: `loc_fail` while BUSY and with no abort pending sets ERROR, empties the read-data FIFO and leaves READY clear.
- R9: `loc_done` while an abort is pending drops the response: the read-data FIFO is emptied and READY stays clear.
- R10: A host write to address 2 while the write-data FIFO is full is ignored and sets ERROR. Firmware sees the FIFO flags `loc_wf_full`, `loc_wf_empty`, `loc_rf_full` and `loc_rf_empty`.
- R11: After reset the status reads zero, both FIFOs are empty and neither interrupt is asserted.
- R12: Host register map. Address 0 is control and reads zero. Address 1 is status: bit 0 READY, bit 1 BUSY, bit 2 ERROR, bit 3 abort pending. A write to address 2 pushes a request dword. A read of address 3 returns the head of the read-data FIFO and pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 2 | Host register address |
| host_wr_data | input | 32 | Host write data |
| host_rd_data | output | 32 | Host read data (combinational on address) |
| irq_go | output | 1 | Request interrupt pulse |
| irq_abort | output | 1 | Abort interrupt pulse |
| loc_rd_en | input | 1 | Pop the write-data FIFO |
| loc_rd_data | output | 32 | Head of the write-data FIFO |
| loc_wf_empty | output | 1 | Write-data FIFO empty |
| loc_wf_full | output | 1 | Write-data FIFO full |
| loc_wr_en | input | 1 | Push a payload dword into the read-data FIFO |
| loc_wr_data | input | 32 | Payload dword |
| loc_rf_empty | output | 1 | Read-data FIFO empty |
| loc_rf_full | output | 1 | Read-data FIFO full |
| req_vendor | output | 16 | Decoded request vendor field |
| req_type | output | 8 | Decoded request type field |
| req_len | output | 19 | Decoded request length in dwords |
| req_hdr_valid | output | 1 | Both request header dwords decoded |
| loc_abort_pend | output | 1 | Abort pending |
| loc_accept | input | 1 | Firmware accepts the request |
| loc_done | input | 1 | Firmware finished the response |
| loc_fail | input | 1 | Firmware reports failure |
| loc_abort_ack | input | 1 | Firmware finished handling an abort |
| resp_hdr_en | input | 1 | Build the response header dwords |
| resp_vendor | input | 16 | Response vendor field |
| resp_type | input | 8 | Response type field |
| resp_pl_dw | input | 18 | Response payload dword count |

## Verification
Every registered result appears one clock edge after its strobe. That covers the interrupts, the decoded header fields, the status bits and the FIFO flags. The second response header dword is the one exception and lands one edge later still. The bench drives strobes on the falling edge and holds them for exactly one rising edge. It samples on the following falling edge, so each check sees the state one cycle after its cause. Host reads are combinational on the address and are sampled before the popping edge.

// File: rtl/doe_mbx_pkg.sv
package doe_mbx_pkg;
  localparam int DW    = 32;
  localparam int LEN_W = 18;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_STATUS = 2'd1;
  localparam logic [1:0] A_WMBX   = 2'd2;
  localparam logic [1:0] A_RMBX   = 2'd3;

  localparam int C_GO    = 0;
  localparam int C_ABORT = 1;

  typedef struct packed {
    logic abort_pend;
    logic error;
    logic busy;
    logic ready;
  } mbx_stat_t;
endpackage

// File: rtl/doe_mbx_fifo.sv
module doe_mbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign rd_data = mem[rptr_q];
  assign do_wr   = wr_en && !full && !flush;
  assign do_rd   = rd_en && !empty && !flush;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_wr) wptr_d = wptr_q + AW'(1);
      if (do_rd) rptr_d = rptr_q + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wr_data;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en && !flush) |=> (count == $past(count)));

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en && !flush) |=> empty);
endmodule

// File: rtl/doe_mbx_hdr_parse.sv
module doe_mbx_hdr_parse #(
  parameter int LEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             pop,
  input  logic [23:0]      data,
  output logic [15:0]      vendor,
  output logic [7:0]       otype,
  output logic [LEN_W:0]   len,
  output logic             valid
);
  logic [1:0]       idx_q, idx_d;
  logic [15:0]      ven_q, ven_d;
  logic [7:0]       typ_q, typ_d;
  logic [LEN_W:0]   len_q, len_d;

  always_comb begin
    idx_d = idx_q;
    ven_d = ven_q;
    typ_d = typ_q;
    len_d = len_q;
    if (clear) begin
      idx_d = 2'd0;
    end else if (pop) begin
      case (idx_q)
        2'd0: begin
          ven_d = data[15:0];
          typ_d = data[23:16];
          idx_d = 2'd1;
        end
        2'd1: begin
          len_d = (data[LEN_W-1:0] == '0) ? {1'b1, {LEN_W{1'b0}}}
                                          : {1'b0, data[LEN_W-1:0]};
          idx_d = 2'd2;
        end
        default: idx_d = idx_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ven_q <= '0;
      typ_q <= '0;
      len_q <= '0;
    end else begin
      idx_q <= idx_d;
      ven_q <= ven_d;
      typ_q <= typ_d;
      len_q <= len_d;
    end
  end

  assign vendor = ven_q;
  assign otype  = typ_q;
  assign len    = len_q;
  assign valid  = (idx_q == 2'd2);

  // R2
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear && idx_q == 2'd1 && data[LEN_W-1:0] == '0)
      |=> (len == {1'b1, {LEN_W{1'b0}}}) && valid);

  // R1
  hdr1_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear && idx_q == 2'd0) |=> (vendor == $past(data[15:0])));
endmodule

// File: rtl/doe_mbx_resp_seq.sv
module doe_mbx_resp_seq #(
  parameter int DW    = 32,
  parameter int LEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      vendor,
  input  logic [7:0]       otype,
  input  logic [LEN_W-1:0] pl_dw,
  output logic             push,
  output logic [DW-1:0]    push_data
);
  logic             pend_q, pend_d;
  logic [LEN_W-1:0] h2_q, h2_d;

  always_comb begin
    pend_d = 1'b0;
    h2_d   = h2_q;
    if (start && !pend_q) begin
      pend_d = 1'b1;
      h2_d   = pl_dw + LEN_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      h2_q   <= '0;
    end else begin
      pend_q <= pend_d;
      h2_q   <= h2_d;
    end
  end

  assign push      = start || pend_q;
  assign push_data = pend_q ? {{(DW-LEN_W){1'b0}}, h2_q}
                            : {{(DW-24){1'b0}}, otype, vendor};

  // R6
  hdr2_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pend_q) |=> (push && push_data[LEN_W-1:0] == LEN_W'($past(pl_dw) + LEN_W'(2))));
endmodule

// File: rtl/doe_mbx_ctrl.sv
module doe_mbx_ctrl
  import doe_mbx_pkg::*;
#(
  parameter int WF_DEPTH = 8,
  parameter int RF_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [1:0]        host_addr,
  input  logic [DW-1:0]     host_wr_data,
  output logic [DW-1:0]     host_rd_data,
  output logic              irq_go,
  output logic              irq_abort,
  input  logic              loc_rd_en,
  output logic [DW-1:0]     loc_rd_data,
  output logic              loc_wf_empty,
  output logic              loc_wf_full,
  input  logic              loc_wr_en,
  input  logic [DW-1:0]     loc_wr_data,
  output logic              loc_rf_empty,
  output logic              loc_rf_full,
  output logic [15:0]       req_vendor,
  output logic [7:0]        req_type,
  output logic [LEN_W:0]    req_len,
  output logic              req_hdr_valid,
  output logic              loc_abort_pend,
  input  logic              loc_accept,
  input  logic              loc_done,
  input  logic              loc_fail,
  input  logic              loc_abort_ack,
  input  logic              resp_hdr_en,
  input  logic [15:0]       resp_vendor,
  input  logic [7:0]        resp_type,
  input  logic [LEN_W-1:0]  resp_pl_dw
);
  localparam int WCW = $clog2(WF_DEPTH+1);
  localparam int RCW = $clog2(RF_DEPTH+1);

  mbx_stat_t st_q, st_d;
  logic      irq_go_q, irq_ab_q;

  logic go_hit, abort_hit, wmbx_wr, wf_ovf, rmbx_rd;
  logic fin_ok, fin_bad, fin_drop, rf_flush, parse_clr;
  logic seq_push, rf_wr_en;
  logic [DW-1:0]  seq_data, rf_wr_data, rf_head;
  logic [WCW-1:0] wf_cnt;
  logic [RCW-1:0] rf_cnt;

  // host strobe decode
  assign go_hit    = host_wr_en && host_addr == A_CTRL && host_wr_data[C_GO];
  assign abort_hit = host_wr_en && host_addr == A_CTRL && host_wr_data[C_ABORT];
  assign wmbx_wr   = host_wr_en && host_addr == A_WMBX;
  assign wf_ovf    = wmbx_wr && loc_wf_full;
  assign rmbx_rd   = host_rd_en && host_addr == A_RMBX && !loc_rf_empty;

  // completion outcomes
  assign fin_ok    = st_q.busy && loc_done && !st_q.abort_pend;
  assign fin_drop  = st_q.busy && loc_done && st_q.abort_pend;
  assign fin_bad   = st_q.busy && loc_fail;
  assign rf_flush  = abort_hit || fin_bad || fin_drop;
  assign parse_clr = abort_hit || (st_q.busy && (loc_done || loc_fail)) || loc_abort_ack;

  always_comb begin
    st_d = st_q;
    // abort pending
    if (abort_hit)          st_d.abort_pend = 1'b1;
    else if (loc_abort_ack) st_d.abort_pend = 1'b0;
    // busy
    if (loc_accept && !st_q.abort_pend && !abort_hit) st_d.busy = 1'b1;
    if (st_q.busy && (loc_done || loc_fail))          st_d.busy = 1'b0;
    if (loc_abort_ack)                                st_d.busy = 1'b0;
    // error
    if (wf_ovf)                                st_d.error = 1'b1;
    if (fin_bad && !st_q.abort_pend)           st_d.error = 1'b1;
    if (abort_hit)                             st_d.error = 1'b0;
    // ready
    if (st_q.ready && rmbx_rd && rf_cnt == RCW'(1)) st_d.ready = 1'b0;
    if (fin_ok)                                     st_d.ready = 1'b1;
    if (rf_flush)                                   st_d.ready = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= '0;
      irq_go_q <= 1'b0;
      irq_ab_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      irq_go_q <= go_hit;
      irq_ab_q <= abort_hit;
    end
  end

  assign irq_go         = irq_go_q;
  assign irq_abort      = irq_ab_q;
  assign loc_abort_pend = st_q.abort_pend;

  always_comb begin
    case (host_addr)
      A_STATUS: host_rd_data = {{(DW-4){1'b0}}, st_q};
      A_RMBX:   host_rd_data = rf_head;
      default:  host_rd_data = '0;
    endcase
  end

  doe_mbx_fifo #(.W(DW), .DEPTH(WF_DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .flush(abort_hit),
    .wr_en(wmbx_wr), .wr_data(host_wr_data),
    .rd_en(loc_rd_en), .rd_data(loc_rd_data),
    .empty(loc_wf_empty), .full(loc_wf_full), .count(wf_cnt)
  );

  doe_mbx_hdr_parse #(.LEN_W(LEN_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .clear(parse_clr),
    .pop(loc_rd_en && !loc_wf_empty), .data(loc_rd_data[23:0]),
    .vendor(req_vendor), .otype(req_type), .len(req_len), .valid(req_hdr_valid)
  );

  doe_mbx_resp_seq #(.DW(DW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(resp_hdr_en),
    .vendor(resp_vendor), .otype(resp_type), .pl_dw(resp_pl_dw),
    .push(seq_push), .push_data(seq_data)
  );

  assign rf_wr_en   = seq_push || loc_wr_en;
  assign rf_wr_data = seq_push ? seq_data : loc_wr_data;

  doe_mbx_fifo #(.W(DW), .DEPTH(RF_DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .flush(rf_flush),
    .wr_en(rf_wr_en), .wr_data(rf_wr_data),
    .rd_en(rmbx_rd), .rd_data(rf_head),
    .empty(loc_rf_empty), .full(loc_rf_full), .count(rf_cnt)
  );

  // R3
  go_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_hit |=> (irq_go && !$past(irq_go)) || (irq_go && $past(go_hit, 2)));

  // R4
  abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (irq_abort && !host_rd_data_status_ready() && loc_wf_empty && loc_rf_empty && loc_abort_pend));

  // R8
  fail_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_bad && !st_q.abort_pend && !abort_hit) |=> (st_q.error && !st_q.ready && !st_q.busy && loc_rf_empty));

  // R9
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_drop |=> (!st_q.ready && loc_rf_empty));

  // R7
  ready_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.ready && rmbx_rd && rf_cnt == RCW'(1) && !fin_ok) |=> !st_q.ready);

  // R10
  wf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wf_full |-> (wf_cnt == WCW'(WF_DEPTH)) && !loc_wf_empty);

  function automatic logic host_rd_data_status_ready();
    return st_q.ready || st_q.error;
  endfunction
endmodule

// File: tb/doe_mbx_ctrl_test.sv
module doe_mbx_ctrl_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 0, host_rd_en = 0;
  logic [1:0]  host_addr = 0;
  logic [31:0] host_wr_data = 0, host_rd_data;
  logic        irq_go, irq_abort;
  logic        loc_rd_en = 0, loc_wr_en = 0;
  logic [31:0] loc_rd_data, loc_wr_data = 0;
  logic        loc_wf_empty, loc_wf_full, loc_rf_empty, loc_rf_full;
  logic [15:0] req_vendor;
  logic [7:0]  req_type;
  logic [18:0] req_len;
  logic        req_hdr_valid, loc_abort_pend;
  logic        loc_accept = 0, loc_done = 0, loc_fail = 0, loc_abort_ack = 0;
  logic        resp_hdr_en = 0;
  logic [15:0] resp_vendor = 0;
  logic [7:0]  resp_type = 0;
  logic [17:0] resp_pl_dw = 0;

  int n_chk = 0, n_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  doe_mbx_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
    .irq_go(irq_go), .irq_abort(irq_abort),
    .loc_rd_en(loc_rd_en), .loc_rd_data(loc_rd_data),
    .loc_wf_empty(loc_wf_empty), .loc_wf_full(loc_wf_full),
    .loc_wr_en(loc_wr_en), .loc_wr_data(loc_wr_data),
    .loc_rf_empty(loc_rf_empty), .loc_rf_full(loc_rf_full),
    .req_vendor(req_vendor), .req_type(req_type), .req_len(req_len),
    .req_hdr_valid(req_hdr_valid), .loc_abort_pend(loc_abort_pend),
    .loc_accept(loc_accept), .loc_done(loc_done), .loc_fail(loc_fail),
    .loc_abort_ack(loc_abort_ack), .resp_hdr_en(resp_hdr_en),
    .resp_vendor(resp_vendor), .resp_type(resp_type), .resp_pl_dw(resp_pl_dw)
  );

  // vector: {hdr1, hdr2, expected req_len, response payload dwords}
  localparam logic [127:0] VEC [0:3] = '{
    {32'h0001_1234, 32'h0000_0003, 32'd3,      32'd1},
    {32'h00FF_ABCD, 32'h0000_0000, 32'd262144, 32'd0},
    {32'h0002_0001, 32'hFFFC_0005, 32'd5,      32'd2},
    {32'h0080_5555, 32'h0003_FFFF, 32'd262143, 32'd3}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wr_data = d; host_wr_en = 1;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd_en = 1;
    #1 d = host_rd_data;
    @(negedge clk);
    host_rd_en = 0;
  endtask

  task automatic lpop(output logic [31:0] d);
    @(negedge clk);
    loc_rd_en = 1;
    #1 d = loc_rd_data;
    @(negedge clk);
    loc_rd_en = 0;
  endtask

  task automatic lpush(input logic [31:0] d);
    @(negedge clk);
    loc_wr_data = d; loc_wr_en = 1;
    @(negedge clk);
    loc_wr_en = 0;
  endtask

  // which: 0 accept, 1 done, 2 fail, 3 abort ack
  task automatic lpulse(input int which);
    @(negedge clk);
    case (which)
      0: loc_accept = 1;
      1: loc_done = 1;
      2: loc_fail = 1;
      default: loc_abort_ack = 1;
    endcase
    @(negedge clk);
    loc_accept = 0; loc_done = 0; loc_fail = 0; loc_abort_ack = 0;
  endtask

  task automatic resp_hdr(input logic [15:0] v, input logic [7:0] t, input logic [17:0] n);
    @(negedge clk);
    resp_vendor = v; resp_type = t; resp_pl_dw = n; resp_hdr_en = 1;
    @(negedge clk);
    resp_hdr_en = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    host_rd(2'd1, d);
    chk("R11 status", d, 0);
    chk("R11 fifo flags", {loc_wf_empty, loc_rf_empty, loc_wf_full, loc_rf_full}, 4'b1100);
    chk("R11 irqs", {irq_go, irq_abort}, 0);
    // R12 control reads zero
    host_rd(2'd0, d);
    chk("R12 ctrl reads zero", d, 0);

    for (int i = 0; i < 4; i++) begin
      logic [31:0] h1, h2, elen, pl;
      {h1, h2, elen, pl} = VEC[i];
      host_wr(2'd2, h1);
      host_wr(2'd2, h2);
      host_wr(2'd0, 32'h1);
      chk("R3 irq_go pulse", irq_go, 1);
      @(negedge clk);
      chk("R3 irq_go one cycle", irq_go, 0);
      lpop(d);
      chk("R1 vendor", req_vendor, h1[15:0]);
      chk("R1 type", req_type, h1[23:16]);
      lpop(d);
      chk("R2 length", req_len, elen);
      chk("R2 header valid", req_hdr_valid, 1);
      lpulse(0);
      host_rd(2'd1, d);
      chk("R5 busy set", d[3:0], 4'b0010);
      resp_hdr(h1[15:0], h1[23:16], pl[17:0]);
      for (int j = 0; j < int'(pl); j++) lpush(32'hA000_0000 + i * 16 + j);
      lpulse(1);
      host_rd(2'd1, d);
      chk("R7 ready after done, R5 busy clear", d[3:0], 4'b0001);
      host_rd(2'd3, d);
      chk("R6 response header 1", d, {8'h00, h1[23:0]});
      host_rd(2'd3, d);
      chk("R6 response header 2", d, pl + 2);
      for (int j = 0; j < int'(pl); j++) begin
        host_rd(2'd3, d);
        chk("R12 payload readback", d, 32'hA000_0000 + i * 16 + j);
      end
      host_rd(2'd1, d);
      chk("R7 ready cleared after drain", d[3:0], 4'b0000);
    end

    // R10 overflow of write FIFO
    for (int k = 0; k < 9; k++) host_wr(2'd2, 32'h100 + k);
    chk("R10 wf full flag", loc_wf_full, 1);
    host_rd(2'd1, d);
    chk("R10 error on overflow", d[2], 1);
    lpop(d);
    chk("R10 first dword kept", d, 32'h100);

    // R4 abort
    host_wr(2'd0, 32'h2);
    chk("R4 irq_abort", irq_abort, 1);
    chk("R4 wf discarded", loc_wf_empty, 1);
    host_rd(2'd1, d);
    chk("R4 status after abort", d[3:0], 4'b1000);
    lpulse(0);
    host_rd(2'd1, d);
    chk("R5 accept ignored while abort pending", d[1], 0);
    lpulse(3);
    chk("R4 abort ack clears pending", loc_abort_pend, 0);

    // R8 failure
    lpulse(0);
    resp_hdr(16'h1111, 8'h22, 18'd1);
    chk("R6 rf holds headers", loc_rf_empty, 0);
    lpulse(2);
    host_rd(2'd1, d);
    chk("R8 status after fail", d[3:0], 4'b0100);
    chk("R8 rf discarded", loc_rf_empty, 1);

    // R9 done while abort pending
    lpulse(0);
    host_wr(2'd0, 32'h2);
    resp_hdr(16'h3333, 8'h44, 18'd0);
    lpulse(1);
    host_rd(2'd1, d);
    chk("R9 dropped, busy clear", d[3:0], 4'b1000);
    chk("R9 rf empty", loc_rf_empty, 1);
    lpulse(3);

    // R6 length wrap: 2^18-2 payload dwords -> field 0
    lpulse(0);
    resp_hdr(16'h5A5A, 8'h01, 18'h3FFFE);
    lpulse(1);
    host_rd(2'd3, d);
    chk("R6 wrap header 1", d, 32'h0001_5A5A);
    host_rd(2'd3, d);
    chk("R6 wrap header 2", d, 0);
    host_rd(2'd1, d);
    chk("R7 ready cleared", d[0], 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule